// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a CPU data-memory request port to an external 8-bit bus on which the low address byte and the data byte share one set of pins (AD). The high address byte has its own pins (AHI). An address-latch strobe (ALE) lets an external transparent latch hold the low address byte. Active-low read and write strobes (RD_N and WR_N) frame the data transfer. Each request is a single-cycle pulse on `req_rd` or `req_wr`. The requester then waits for a one-cycle `req_ready` pulse before it issues the next request.

The block compares every request address with the parameter `INT_TOP`, which is the top of the internal SRAM. Addresses above it go to the external bus. Addresses at or below it are internal: they still drive address and ALE activity on the bus, but the strobes stay high. Two configuration inputs control the bus:
- `cfg_en` turns the bus on. While the bus is on, the block takes over the pins from the general-purpose port.
- `cfg_wait` adds 0 to 3 wait cycles to the strobe phase.

When the bus is off, the pins carry the port's own values and directions. Addresses above the boundary are then unmapped.

Top module: `xbus_ctrl`

## Requirements
- R1: An address greater than `INT_TOP` (default 0x21FF) is external. An address less than or equal to `INT_TOP` is internal. So 0x21FF is internal and 0x2200 is external.
- R2: Every enabled access has one cycle with ALE high, in which AD carries address[7:0] and AHI carries address[15:8]. When ALE falls, AD still carries the same low address byte, so a latch that closes on that edge captures the requested address.
- R3: ALE is low in every cycle in which RD_N or WR_N is low.
- R4: An external read holds RD_N low for exactly 1+`cfg_wait` consecutive cycles. AD output enables are off while RD_N is low. The read data is the value on `pad_ad_i` in the last RD_N-low cycle.
- R5: An external write holds WR_N low for exactly 1+`cfg_wait` cycles. In every WR_N-low cycle, AD drives the write data with all output enables on.
- R6: RD_N and WR_N are never low in the same cycle.
- R7: An enabled internal access pulses ALE and drives the address, but leaves RD_N and WR_N high. It returns ready 5 cycles after the request edge, whatever the value of `cfg_wait`, and returns read data 0x00.
- R8: If the request is sampled at clock edge E0, an enabled external access raises `req_ready` in cycle 5+`cfg_wait` after E0. `req_ready` is a one-cycle pulse.
- R9: While disabled and idle, each pad output and output enable equals the corresponding `gp_*` value. An internal request completes with ready in the first cycle after the request edge, and no ALE pulse appears.
- R10: While disabled, an access above `INT_TOP` is unmapped. It completes with ready in the first cycle after the request edge and returns 0x00. No strobe is driven, and a write leaves the external memory unchanged.
- R11: While enabled, the AHI output enables and all three control-pin enables are on, whatever the values of `gp_ahi_oe` and `gp_ctl_oe`. The control-pin vector is ordered {WR_N, RD_N, ALE}, from bit 2 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Bus enable |
| cfg_wait | input | 2 | Extra strobe cycles, 0 to 3 |
| req_rd | input | 1 | Read request pulse |
| req_wr | input | 1 | Write request pulse |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 8 | Read data, valid with ready |
| req_ready | output | 1 | Access complete pulse |
| gp_ad_o | input | 8 | Port value for the AD pins |
| gp_ad_oe | input | 8 | Port direction for the AD pins |
| gp_ahi_o | input | 8 | Port value for the AHI pins |
| gp_ahi_oe | input | 8 | Port direction for the AHI pins |
| gp_ctl_o | input | 3 | Port values for {WR_N, RD_N, ALE} pins |
| gp_ctl_oe | input | 3 | Port directions for {WR_N, RD_N, ALE} pins |
| pad_ad_i | input | 8 | Value read back from the AD pins |
| pad_ad_o | output | 8 | AD pin output value |
| pad_ad_oe | output | 8 | AD pin output enables |
| pad_ahi_o | output | 8 | High address pin values |
| pad_ahi_oe | output | 8 | High address pin enables |
| pad_ale | output | 1 | Address latch enable pin |
| pad_rd_n | output | 1 | Read strobe pin, active low |
| pad_wr_n | output | 1 | Write strobe pin, active low |
| pad_ctl_oe | output | 3 | Enables for {WR_N, RD_N, ALE} pins |

## Verification
The assertions assume that a request is a single-cycle pulse issued only while the block is idle. They also assume that `req_rd` and `req_wr` are never raised together. The stimulus keeps to this by issuing each request from a task that drops it after one clock and waits for `req_ready` before starting the next one. `cfg_wait` and `cfg_en` are changed only between accesses. The strobe-width property can therefore compare against the wait count captured at the request.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Bus phase of the sequencer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_SETUP,
        ST_STRB
    } xb_state_e;

    // Classification of a request address
    typedef enum logic [1:0] {
        CLS_INT,
        CLS_EXT,
        CLS_NONE
    } xb_class_e;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] INT_TOP = 16'h21FF
) (
    input  logic [AW-1:0] addr,
    input  logic          enable,
    output xb_class_e     cls
);

    logic above;

    // R1: strictly above the internal top goes outside
    assign above = (addr > INT_TOP);

    always_comb begin
        if (!above)
            cls = CLS_INT;
        else if (enable)
            cls = CLS_EXT;
        else
            cls = CLS_NONE;   // R10: unmapped while disabled
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int WSW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic [WSW-1:0]  cfg_wait,
    input  logic            req_rd,
    input  logic            req_wr,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  xb_class_e       cls,
    input  logic [DW-1:0]   pad_ad_i,
    output logic            busy,
    output logic            ale,
    output logic            rd_n,
    output logic            wr_n,
    output logic [DW-1:0]   ad_o,
    output logic            ad_drive,
    output logic [AW-DW-1:0] ahi,
    output logic            ready,
    output logic [DW-1:0]   rdata
);

    localparam int HIW = AW - DW;

    typedef struct packed {
        xb_state_e      st;
        logic           ext;
        logic           wr;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [WSW-1:0] ws;
        logic [WSW-1:0] cnt;
        logic           ready;
        logic [DW-1:0]  rdata;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.ready = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_rd || req_wr) begin
                    d.rdata = '0;
                    if (cls == CLS_EXT || (cls == CLS_INT && cfg_en)) begin
                        d.st    = ST_ADDR;
                        d.ext   = (cls == CLS_EXT);
                        d.wr    = req_wr;
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.ws    = (cls == CLS_EXT) ? cfg_wait : '0;
                        d.cnt   = d.ws;
                    end else begin
                        d.ready = 1'b1;   // disabled internal or unmapped
                    end
                end
            end
            ST_ADDR:  d.st = ST_HOLD;
            ST_HOLD:  d.st = ST_SETUP;
            ST_SETUP: d.st = ST_STRB;
            ST_STRB: begin
                if (q.cnt == '0) begin
                    d.st    = ST_IDLE;
                    d.ready = 1'b1;
                    if (q.ext && !q.wr)
                        d.rdata = pad_ad_i;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // Pin-side decode of the registered phase
    logic strobe_on;
    assign strobe_on = (q.st == ST_STRB) && q.ext;
    assign busy      = (q.st != ST_IDLE);
    assign ale       = (q.st == ST_ADDR);
    assign rd_n      = !(strobe_on && !q.wr);
    assign wr_n      = !(strobe_on &&  q.wr);
    assign ahi       = q.addr[AW-1 -: HIW];
    assign ready     = q.ready;
    assign rdata     = q.rdata;

    always_comb begin
        ad_o     = '0;
        ad_drive = 1'b0;
        unique case (q.st)
            ST_ADDR, ST_HOLD: begin
                ad_o     = q.addr[DW-1:0];
                ad_drive = 1'b1;
            end
            ST_SETUP, ST_STRB: begin
                ad_o     = q.wdata;
                ad_drive = q.wr;
            end
            default: ;
        endcase
    end

    // Strobe-width measurement for the checks below
    logic           strb_now, strb_was;
    logic [WSW:0]   slen_q;
    assign strb_now = !rd_n || !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_was <= 1'b0;
            slen_q   <= '0;
        end else begin
            strb_was <= strb_now;
            slen_q   <= strb_now ? slen_q + 1'b1 : '0;
        end
    end

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_ale_low_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);

    p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_drive && ad_o == $past(ad_o)));

    p_int_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.ext) |-> (rd_n && wr_n));

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_now && strb_was) |-> (slen_q == {1'b0, q.ws} + 1'b1));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins #(
    parameter int DW  = 8,
    parameter int HIW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            owned,
    input  logic            ale,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [DW-1:0]   ad_o,
    input  logic            ad_drive,
    input  logic [HIW-1:0]  ahi,
    input  logic [DW-1:0]   gp_ad_o,
    input  logic [DW-1:0]   gp_ad_oe,
    input  logic [HIW-1:0]  gp_ahi_o,
    input  logic [HIW-1:0]  gp_ahi_oe,
    input  logic [2:0]      gp_ctl_o,
    input  logic [2:0]      gp_ctl_oe,
    output logic [DW-1:0]   pad_ad_o,
    output logic [DW-1:0]   pad_ad_oe,
    output logic [HIW-1:0]  pad_ahi_o,
    output logic [HIW-1:0]  pad_ahi_oe,
    output logic            pad_ale,
    output logic            pad_rd_n,
    output logic            pad_wr_n,
    output logic [2:0]      pad_ctl_oe
);

    logic [2:0] bus_ctl;
    logic [2:0] ctl_mux;
    assign bus_ctl = {wr_n, rd_n, ale};

    for (genvar i = 0; i < DW; i++) begin : g_ad
        assign pad_ad_o[i]  = owned ? ad_o[i]  : gp_ad_o[i];
        assign pad_ad_oe[i] = owned ? ad_drive : gp_ad_oe[i];
    end

    for (genvar j = 0; j < HIW; j++) begin : g_ahi
        assign pad_ahi_o[j]  = owned ? ahi[j] : gp_ahi_o[j];
        assign pad_ahi_oe[j] = owned | gp_ahi_oe[j];
    end

    for (genvar k = 0; k < 3; k++) begin : g_ctl
        assign ctl_mux[k]    = owned ? bus_ctl[k] : gp_ctl_o[k];
        assign pad_ctl_oe[k] = owned | gp_ctl_oe[k];
    end

    assign pad_ale  = ctl_mux[0];
    assign pad_rd_n = ctl_mux[1];
    assign pad_wr_n = ctl_mux[2];

    p_own_ctl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        owned |-> (&pad_ctl_oe && &pad_ahi_oe));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !owned |-> (pad_ad_oe == gp_ad_oe && pad_ctl_oe == gp_ctl_oe));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int WSW = 2,
    parameter logic [AW-1:0] INT_TOP = 16'h21FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [WSW-1:0]    cfg_wait,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic [DW-1:0]     req_rdata,
    output logic              req_ready,
    input  logic [DW-1:0]     gp_ad_o,
    input  logic [DW-1:0]     gp_ad_oe,
    input  logic [AW-DW-1:0]  gp_ahi_o,
    input  logic [AW-DW-1:0]  gp_ahi_oe,
    input  logic [2:0]        gp_ctl_o,
    input  logic [2:0]        gp_ctl_oe,
    input  logic [DW-1:0]     pad_ad_i,
    output logic [DW-1:0]     pad_ad_o,
    output logic [DW-1:0]     pad_ad_oe,
    output logic [AW-DW-1:0]  pad_ahi_o,
    output logic [AW-DW-1:0]  pad_ahi_oe,
    output logic              pad_ale,
    output logic              pad_rd_n,
    output logic              pad_wr_n,
    output logic [2:0]        pad_ctl_oe
);

    localparam int HIW = AW - DW;

    xb_class_e        cls;
    logic             busy, ale, rd_n, wr_n, ad_drive, owned;
    logic [DW-1:0]    ad_o;
    logic [HIW-1:0]   ahi;

    xbus_decode #(.AW(AW), .INT_TOP(INT_TOP)) u_decode (
        .addr   (req_addr),
        .enable (cfg_en),
        .cls    (cls)
    );

    xbus_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_wait  (cfg_wait),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cls       (cls),
        .pad_ad_i  (pad_ad_i),
        .busy      (busy),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_o      (ad_o),
        .ad_drive  (ad_drive),
        .ahi       (ahi),
        .ready     (req_ready),
        .rdata     (req_rdata)
    );

    // The bus keeps its pins until an access in flight completes
    assign owned = cfg_en || busy;

    xbus_pins #(.DW(DW), .HIW(HIW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .owned      (owned),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ad_o       (ad_o),
        .ad_drive   (ad_drive),
        .ahi        (ahi),
        .gp_ad_o    (gp_ad_o),
        .gp_ad_oe   (gp_ad_oe),
        .gp_ahi_o   (gp_ahi_o),
        .gp_ahi_oe  (gp_ahi_oe),
        .gp_ctl_o   (gp_ctl_o),
        .gp_ctl_oe  (gp_ctl_oe),
        .pad_ad_o   (pad_ad_o),
        .pad_ad_oe  (pad_ad_oe),
        .pad_ahi_o  (pad_ahi_o),
        .pad_ahi_oe (pad_ahi_oe),
        .pad_ale    (pad_ale),
        .pad_rd_n   (pad_rd_n),
        .pad_wr_n   (pad_wr_n),
        .pad_ctl_oe (pad_ctl_oe)
    );

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic [1:0]  cfg_wait = 2'd0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  req_rdata;
    logic        req_ready;
    logic [7:0]  gp_ad_o = 8'h5A, gp_ad_oe = 8'h0F;
    logic [7:0]  gp_ahi_o = 8'hC3, gp_ahi_oe = 8'h00;
    logic [2:0]  gp_ctl_o = 3'b110, gp_ctl_oe = 3'b000;
    logic [7:0]  pad_ad_i;
    logic [7:0]  pad_ad_o, pad_ad_oe, pad_ahi_o, pad_ahi_oe;
    logic        pad_ale, pad_rd_n, pad_wr_n;
    logic [2:0]  pad_ctl_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl uut (.*);

    // External transparent latch and SRAM model
    logic [7:0] lat_lo = '0, lat_hi = '0;
    logic [7:0] mem [512];

    always @(negedge pad_ale) begin
        lat_lo = pad_ad_o;
        lat_hi = pad_ahi_o;
    end

    assign pad_ad_i = !pad_rd_n ? mem[{lat_hi[0], lat_lo}] : 8'h00;

    always @(negedge clk)
        if (!pad_wr_n && pad_ad_oe == 8'hFF)
            mem[{lat_hi[0], lat_lo}] <= pad_ad_o;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic wr, input logic [15:0] a, input logic [7:0] d,
                             output logic [7:0] rdv, output int lat, output int alec,
                             output int rdc, output int wrc);
        lat = 0; alec = 0; rdc = 0; wrc = 0;
        @(negedge clk);
        req_addr = a; req_wdata = d; req_wr = wr; req_rd = !wr;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0; lat = 1;
        while (!req_ready && lat < 40) begin
            if (pad_ale) alec++;
            if (!pad_rd_n) begin
                rdc++;
                chk(pad_ad_oe == 8'h00, "R4 AD released", pad_ad_oe, 0);
            end
            if (!pad_wr_n) begin
                wrc++;
                chk(pad_ad_oe == 8'hFF && pad_ad_o == d, "R5 write data", pad_ad_o, d);
            end
            if (!pad_rd_n && !pad_wr_n) chk(1'b0, "R6 both strobes", 1, 0);
            if ((!pad_rd_n || !pad_wr_n) && pad_ale) chk(1'b0, "R3 ALE in strobe", 1, 0);
            @(negedge clk);
            lat++;
        end
        rdv = req_rdata;
        @(negedge clk);
        chk(!req_ready, "R8 ready pulse", req_ready, 0);
    endtask

    // {wr, ws, addr, wdata, expected read data}
    localparam logic [34:0] VEC [12] = '{
        {1'b1, 2'd0, 16'h2200, 8'h3C, 8'h00},
        {1'b1, 2'd1, 16'h2301, 8'hA5, 8'h00},
        {1'b1, 2'd3, 16'hFFAA, 8'h0F, 8'h00},
        {1'b1, 2'd2, 16'h8055, 8'hE1, 8'h00},
        {1'b0, 2'd0, 16'h2200, 8'h00, 8'h3C},
        {1'b0, 2'd1, 16'h2301, 8'h00, 8'hA5},
        {1'b0, 2'd2, 16'hFFAA, 8'h00, 8'h0F},
        {1'b0, 2'd3, 16'h8055, 8'h00, 8'hE1},
        {1'b1, 2'd0, 16'h2200, 8'h11, 8'h00},
        {1'b0, 2'd3, 16'h2200, 8'h00, 8'h11},
        {1'b0, 2'd0, 16'h21FF, 8'h00, 8'h00},
        {1'b1, 2'd2, 16'h0100, 8'h99, 8'h00}
    };

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int lat, alec, rdc, wrc;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;

        // Reset state
        repeat (3) @(negedge clk);
        chk(!req_ready, "R8 reset ready", req_ready, 0);
        chk(!pad_ale && pad_rd_n && pad_wr_n, "R6 reset strobes",
            {pad_wr_n, pad_rd_n, pad_ale}, 3'b110);
        chk(pad_ad_oe == 8'h00, "R4 reset AD enables", pad_ad_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(&pad_ahi_oe && &pad_ctl_oe, "R11 enabled override",
            {pad_ahi_oe, pad_ctl_oe}, 11'h7FF);

        // Vector table
        for (int v = 0; v < 12; v++) begin
            logic        wr;
            logic [1:0]  ws;
            logic [15:0] a;
            logic [7:0]  wd, ex;
            bit          ext;
            wr = VEC[v][34]; ws = VEC[v][33:32]; a = VEC[v][31:16];
            wd = VEC[v][15:8]; ex = VEC[v][7:0];
            ext = (a > 16'h21FF);
            cfg_wait = ws;
            do_access(wr, a, wd, rv, lat, alec, rdc, wrc);
            chk(alec == 1, "R2 one ALE cycle", alec, 1);
            chk({lat_hi, lat_lo} == a, "R2 latched address", {lat_hi, lat_lo}, a);
            if (ext) begin
                chk(lat == 5 + ws, "R8 external latency", lat, 5 + ws);
                chk(rdc == (wr ? 0 : 1 + ws), "R4 RD width", rdc, wr ? 0 : 1 + ws);
                chk(wrc == (wr ? 1 + ws : 0), "R5 WR width", wrc, wr ? 1 + ws : 0);
            end else begin
                chk(lat == 5, "R7 internal latency", lat, 5);
                chk(rdc == 0 && wrc == 0, "R7 strobes quiet", rdc + wrc, 0);
            end
            if (!wr) chk(rv == ex, "R4 read data", rv, ex);
        end

        // R1 boundary: 0x2200 reads as external with strobe, 0x21FF as internal
        cfg_wait = 2'd0;
        do_access(1'b0, 16'h2200, 8'h00, rv, lat, alec, rdc, wrc);
        chk(rdc == 1 && lat == 5, "R1 0x2200 external", rdc, 1);
        do_access(1'b0, 16'h21FF, 8'h00, rv, lat, alec, rdc, wrc);
        chk(rdc == 0, "R1 0x21FF internal", rdc, 0);

        // Disabled: pins revert to port settings
        cfg_en = 1'b0;
        @(negedge clk);
        chk(pad_ad_o == gp_ad_o && pad_ad_oe == gp_ad_oe, "R9 AD released",
            {pad_ad_o, pad_ad_oe}, {gp_ad_o, gp_ad_oe});
        chk(pad_ahi_o == gp_ahi_o && pad_ahi_oe == gp_ahi_oe, "R9 AHI released",
            {pad_ahi_o, pad_ahi_oe}, {gp_ahi_o, gp_ahi_oe});
        chk(pad_ctl_oe == gp_ctl_oe && {pad_wr_n, pad_rd_n, pad_ale} == gp_ctl_o,
            "R9 control released", {pad_wr_n, pad_rd_n, pad_ale}, gp_ctl_o);
        do_access(1'b0, 16'h0100, 8'h00, rv, lat, alec, rdc, wrc);
        chk(lat == 1 && alec == 0, "R9 internal while disabled", lat, 1);

        // Disabled: above boundary is unmapped
        do_access(1'b1, 16'h2200, 8'h77, rv, lat, alec, rdc, wrc);
        chk(lat == 1 && wrc == 0, "R10 unmapped write", lat, 1);
        do_access(1'b0, 16'h2200, 8'h00, rv, lat, alec, rdc, wrc);
        chk(lat == 1 && rdc == 0 && rv == 8'h00, "R10 unmapped read", rv, 0);

        // Re-enable: the unmapped write left memory unchanged
        cfg_en = 1'b1;
        cfg_wait = 2'd1;
        do_access(1'b0, 16'h2200, 8'h00, rv, lat, alec, rdc, wrc);
        chk(rv == 8'h11, "R10 memory untouched", rv, 8'h11);
        chk(rdc == 2, "R4 RD width re-enabled", rdc, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule